// File: doc/BRIEF.md
# RAM-Backed Fixed Delay Line

This block delays a stream of words by a fixed number of clock cycles. The result is the same as a chain of registers of that length, but the words are kept in a simple dual-port memory and are never moved. Each cycle one new word is written at the write address and one stored word is read from the read address. Both addresses then move on by one. The two addresses stay a fixed distance apart, so each word is read back exactly one delay period after it was written.

The block suits long delays where a flip-flop chain would cost too much area. Examples are aligning a data stream with a slow side path, or holding a line of samples for a filter. The delay equals the memory depth, 2^ADDR_W. There is no way to stall the block or change the length at run time. A small fill flag forces the output to zero until the first stored word comes back. So after reset the output looks exactly like a register chain that was cleared, even though the memory itself is never cleared.

Top module: `ram_delay_line`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the output `dout` is zero after that edge.
- R2: A synchronous reset puts the read address at zero and the write address at all ones (DEPTH-1). The first input word sampled after reset appears at `dout` after exactly DEPTH rising edges.
- R3: Outside reset, the read address and the write address each advance by one on every rising edge. Each wraps from DEPTH-1 to zero.
- R4: The read address always equals the write address plus one, modulo DEPTH. A word is therefore never read in the same cycle that it is written.
- R5: The value at `dout` after rising edge n equals the `din` value sampled at edge n-DEPTH+1. This is the same as a chain of DEPTH registers that is cleared by reset.
- R6: For the first DEPTH-1 rising edges after reset is released, `dout` is zero, whatever is on `din`.
- R7: A reset in the middle of a run throws away every stored word. The zero-fill of R6 and the delay of R5 then start again from the edge that follows the reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every register samples on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| din | input | DATA_W | Input word, taken on every rising edge outside reset |
| dout | output | DATA_W | Input word delayed by DEPTH cycles; zero until the memory has filled |

## Verification
The bench drives a ramp so that it can pin down the exact edge where the first real word comes out. A pointer offset that is off by one shows up there as a delay of DEPTH-1 or DEPTH+1 cycles. Zero-fill is tested by holding non-zero input during the first DEPTH cycles. If the output mask were missing, stale or undefined memory contents would leak out instead of zeros. The bench runs long random stretches that wrap the addresses many times, and also drives alternating and all-ones patterns. These would catch a bad wrap, a swapped address, or a read that returns the word being written in the same cycle. A reset in the middle of a run checks that no word from before the reset ever reaches the output.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Per-cycle strobes passed from the control to the datapath
  typedef struct packed {
    logic wrEn;     // store din at the write address this edge
    logic rdEn;     // fetch the word at the read address this edge
    logic rdValid;  // the fetched word was written after the last reset
  } dlStrobe_t;

endpackage

// File: rtl/dl_control.sv
module dl_control
  import dl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr,
  output dlStrobe_t         strobe
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = '1;
  localparam logic [ADDR_W-1:0] ONE_ADDR  = ADDR_W'(1);

  logic [ADDR_W-1:0] wrPtr;
  logic [ADDR_W-1:0] rdPtr;
  logic              primed;

  // The read pointer starts at the first entry and the write pointer at
  // the last. Both step every cycle, so their offset never changes.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdPtr  <= '0;
      wrPtr  <= LAST_ADDR;
      primed <= 1'b0;
    end else begin
      rdPtr <= rdPtr + ONE_ADDR;
      wrPtr <= wrPtr + ONE_ADDR;
      if (rdPtr == LAST_ADDR) begin
        primed <= 1'b1;
      end
    end
  end

  // The first read that returns live data is the one at the last entry,
  // which the first post-reset write filled.
  always_comb begin
    strobe.wrEn    = !rst;
    strobe.rdEn    = !rst;
    strobe.rdValid = primed | (rdPtr == LAST_ADDR);
  end

  assign wrAddr = wrPtr;
  assign rdAddr = rdPtr;

endmodule

// File: rtl/dl_ram.sv
module dl_ram #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Simple dual port: one write port, one registered read port, no reset
  always_ff @(posedge clk) begin
    if (wrEn) begin
      mem[wrAddr] <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rdEn) begin
      rdData <= mem[rdAddr];
    end
  end

endmodule

// File: rtl/dl_datapath.sv
module dl_datapath
  import dl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  dlStrobe_t         strobe,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [DATA_W-1:0] rdData;
  logic              liveQ;

  dl_ram #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_ram (
    .clk   (clk),
    .wrEn  (strobe.wrEn),
    .wrAddr(wrAddr),
    .wrData(din),
    .rdEn  (strobe.rdEn),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  // Tracks whether the word now on rdData belongs to the current run
  always_ff @(posedge clk) begin
    if (rst) begin
      liveQ <= 1'b0;
    end else begin
      liveQ <= strobe.rdEn & strobe.rdValid;
    end
  end

  assign dout = liveQ ? rdData : '0;

endmodule

// File: rtl/ram_delay_line.sv
module ram_delay_line
  import dl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout
);

  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;
  dlStrobe_t         strobe;

  dl_control #(
    .ADDR_W(ADDR_W)
  ) u_ctl (
    .clk   (clk),
    .rst   (rst),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .strobe(strobe)
  );

  dl_datapath #(
    .DATA_W(DATA_W),
    .ADDR_W(ADDR_W)
  ) u_dp (
    .clk   (clk),
    .rst   (rst),
    .strobe(strobe),
    .wrAddr(wrAddr),
    .rdAddr(rdAddr),
    .din   (din),
    .dout  (dout)
  );

endmodule

// File: rtl/dl_checker.sv
module dl_checker #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] din,
  input logic [DATA_W-1:0] dout,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [ADDR_W-1:0] rdAddr
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W:0]   fillCnt;
  logic [DATA_W-1:0] refChain [DEPTH];

  // Counts edges since reset, and stops counting once it reaches DEPTH
  always_ff @(posedge clk) begin
    if (rst) begin
      fillCnt <= '0;
    end else if (fillCnt < (ADDR_W+1)'(DEPTH)) begin
      fillCnt <= fillCnt + 1'b1;
    end
  end

  // Reference: a plain register chain of the same length, cleared by reset
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) refChain[i] <= '0;
    end else begin
      refChain[0] <= din;
      for (int i = 1; i < DEPTH; i++) refChain[i] <= refChain[i-1];
    end
  end

  // R1, R2
  p_reset_state_r2: assert property (@(posedge clk)
    rst |=> (rdAddr == '0 && wrAddr == '1 && dout == '0));

  // R3
  p_rd_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> rdAddr == $past(rdAddr) + 1'b1);

  // R3
  p_wr_step_r3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> wrAddr == $past(wrAddr) + 1'b1);

  // R4
  p_ptr_offset_r4: assert property (@(posedge clk) disable iff (rst)
    rdAddr == wrAddr + 1'b1);

  // R6, R7
  p_zero_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (fillCnt < (ADDR_W+1)'(DEPTH)) |-> dout == '0);

  // R5
  p_chain_match_r5: assert property (@(posedge clk) disable iff (rst)
    dout == refChain[DEPTH-1]);

endmodule

bind ram_delay_line dl_checker #(
  .DATA_W(DATA_W),
  .ADDR_W(ADDR_W)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .din   (din),
  .dout  (dout),
  .wrAddr(wrAddr),
  .rdAddr(rdAddr)
);

// File: tb/tb_ram_delay_line.sv
module tb_ram_delay_line;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_W     = 8;
  localparam int ADDR_W     = 4;
  localparam int DEPTH      = 1 << ADDR_W;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] din = '0;
  logic [DATA_W-1:0] dout;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [DATA_W-1:0] model [DEPTH];

  ram_delay_line #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) dut (
    .clk(clk), .rst(rst), .din(din), .dout(dout)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] expectedOut();
    return model[DEPTH-1];
  endfunction

  task automatic checkVal(string tag, logic [DATA_W-1:0] got, logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: dout=%0h expected=%0h at %0t", tag, got, exp, $time);
    end
  endtask

  // Applies one cycle of stimulus, lets the model follow the edge, then checks at the falling edge
  task automatic step(logic r, logic [DATA_W-1:0] d, string tag);
    rst = r;
    din = d;
    @(posedge clk);
    if (r) begin
      for (int i = 0; i < DEPTH; i++) model[i] = '0;
    end else begin
      for (int i = DEPTH-1; i > 0; i--) model[i] = model[i-1];
      model[0] = d;
    end
    @(negedge clk);
    checkVal(tag, dout, expectedOut());
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
    void'($urandom(32'h5EED_1234));
    @(negedge clk);
    // R1: reset state
    for (int i = 0; i < 3; i++) step(1'b1, 8'hA5, "R1");
    // R6 / R2: ramp of non-zero words; the first one must emerge after exactly DEPTH edges
    for (int i = 0; i < DEPTH - 1; i++) begin
      step(1'b0, DATA_W'(i + 1), "R6");
      checkVal("R6", dout, '0);
    end
    step(1'b0, DATA_W'(DEPTH), "R2");
    checkVal("R2", dout, 8'd1);
    for (int i = 0; i < 2*DEPTH; i++) step(1'b0, DATA_W'(DEPTH + 1 + i), "R5");
    // R3 / R5: random traffic wrapping the addresses many times
    for (int i = 0; i < 20*DEPTH; i++) step(1'b0, DATA_W'($urandom), "R3");
    // R5: alternating and all-ones patterns
    for (int i = 0; i < 2*DEPTH; i++) step(1'b0, (i % 2) ? 8'h55 : 8'hAA, "R5");
    for (int i = 0; i < 2*DEPTH; i++) step(1'b0, 8'hFF, "R5");
    // R4: a word must never be read in the cycle it is written; back-to-back distinct words
    for (int i = 0; i < 3*DEPTH; i++) step(1'b0, DATA_W'(i * 7 + 3), "R4");
    // R7: mid-run reset discards stored words and restarts the fill
    step(1'b1, 8'h3C, "R7");
    checkVal("R7", dout, '0);
    for (int i = 0; i < DEPTH - 1; i++) begin
      step(1'b0, 8'hC3, "R7");
      checkVal("R7", dout, '0);
    end
    step(1'b0, 8'h81, "R7");
    checkVal("R7", dout, 8'hC3);
    for (int i = 0; i < 4*DEPTH; i++) step(1'b0, DATA_W'($urandom), "R7");
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, failures);
      $finish;
    end
  end

endmodule